// File: doc/BRIEF.md
# Frame Rate Speed Mode Detector

This block decides which speed band an incoming audio stream belongs to. It times the interval between rising edges of the frame clock (one edge per stereo sample) in cycles of a fixed reference clock. It then sorts that interval into single, double or quad speed. Intervals that fall between the bands, or outside them, are reported as unsupported. A band change is reported only after the same result has been seen on several consecutive frames. This stops a jittery or switching source from toggling the downstream filter configuration.

Over each frame the block also counts master clock enable pulses. That count gives the master-to-frame clock ratio. The ratio is matched against a set of nominal values within a small tolerance, and it is marked valid only when the matched value is legal for the band currently reported. A de-emphasis request is passed through only while the block reports single speed. The frame clock is synchronized inside the block. The master clock enable is expected to be a single-cycle pulse that is already in the reference clock domain.

Top module: `fs_mode_detect`

## Requirements
- R1: After reset, mode_o is 2'b11, mode_valid_o is 0, ratio_code_o is 3'b111, ratio_valid_o is 0 and deemph_en_o is 0.
- R2: A frame period P is the number of reference cycles between two consecutive rising frame edges. P is classified as quad speed (code 2'b10) when ceil(REF_HZ/QD_HI_HZ) <= P <= floor(REF_HZ/QD_LO_HZ), as double speed (2'b01) when ceil(REF_HZ/DBL_HI_HZ) <= P <= floor(REF_HZ/DBL_LO_HZ), and as single speed (2'b00) when ceil(REF_HZ/SGL_HI_HZ) <= P <= floor(REF_HZ/SGL_LO_HZ).
- R3: Any other period is classified as unsupported. This includes the gap between the single and double bands and the gap between the double and quad bands. Once an unsupported result is reported, mode_o reads 2'b11 and mode_valid_o reads 0. mode_valid_o is 1 exactly when mode_o is one of the three band codes.
- R4: The reported mode changes only after ACCEPT (default 4) consecutive frames give the same new classification. A differing classification restarts the count. Band changes need no reset or external control.
- R5: N is the number of mclk_en_i pulses in one frame. At each measured frame edge, ratio_code_o is set to the index of the nominal ratio that N matches within +-RATIO_TOL (default 2). The indices are 0:128, 1:192, 2:256, 3:384, 4:512 and 5:768. When N matches none of them, ratio_code_o is set to 3'b111.
- R6: ratio_valid_o is 1 only when mode_valid_o is 1 and ratio_code_o is legal for mode_o. The legal indices are 2..5 in single speed, 0..3 in double speed and 0..1 in quad speed.
- R7: The frame clock may show no rising edge for more than floor(REF_HZ/SGL_LO_HZ)+1 reference cycles. In that case mode_o is forced to 2'b11 and ratio_code_o to 3'b111 at once, without the consecutive-frame count. The next rising edge only restarts the measurement and gives no classification.
- R8: deemph_en_o equals deemph_req_i while mode_o is 2'b00, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fixed-frequency reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_clk_i | input | 1 | Frame (left/right) clock; synchronized internally |
| mclk_en_i | input | 1 | One pulse per master clock cycle, in the clk_i domain |
| deemph_req_i | input | 1 | De-emphasis request |
| mode_o | output | 2 | Reported speed band: 00 single, 01 double, 10 quad, 11 unsupported |
| mode_valid_o | output | 1 | Reported band is supported |
| ratio_code_o | output | 3 | Matched master-to-frame ratio index, 7 when no match |
| ratio_valid_o | output | 1 | Ratio is legal for the reported band |
| deemph_en_o | output | 1 | De-emphasis enable, single speed only |

## Verification
The bench sweeps frame periods one cycle either side of every band edge, and it also probes the middle of the gap between single and double speed. An off-by-one bound would then misreport exactly one of those periods, and a missing gap would report a band where none is supported. Ratios are driven at each nominal value, at the tolerance limits and one count beyond them, and at values that are legal only in another band. A design that ignored the per-band legal set would flag those as valid. Two hysteresis sequences are run. In the first, three consecutive frames of a new band must not switch the mode but the fourth must. In the second, a single interrupting frame must restart the count, so a design that never cleared its counter would switch too early. A stopped frame clock is held just below and just beyond the limit, so a late or missing timeout shows up as a stale valid mode.

// File: rtl/fs_mode_pkg.sv
package fs_mode_pkg;

  typedef enum logic [1:0] {
    SPD_SGL  = 2'b00,
    SPD_DBL  = 2'b01,
    SPD_QD   = 2'b10,
    SPD_NONE = 2'b11
  } spd_e;

  localparam int          NUM_RATIOS = 6;
  localparam logic [2:0]  RATIO_NONE = 3'b111;

  // 128,192,256,384,512,768
  function automatic int ratio_nominal(input int idx);
    int base;
    base = 128 << (idx >> 1);
    return (idx % 2 == 1) ? base + base / 2 : base;
  endfunction

  function automatic logic ratio_legal(input spd_e m, input logic [2:0] code);
    logic ok;
    case (m)
      SPD_SGL: ok = (code >= 3'd2) && (code <= 3'd5);
      SPD_DBL: ok = (code <= 3'd3);
      SPD_QD:  ok = (code <= 3'd1);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/fs_frame_meter.sv
module fs_frame_meter #(
  parameter int PER_SAT = 25001,
  parameter int PER_W   = 15,
  parameter int MCK_W   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_clk_i,
  input  logic             mclk_en_i,
  output logic             meas_o,
  output logic             stall_o,
  output logic [PER_W-1:0] period_o,
  output logic [MCK_W-1:0] mck_o
);

  logic [2:0]       sync_q;
  logic             rise;
  logic             armed_q;
  logic [PER_W-1:0] per_q;
  logic [MCK_W-1:0] mck_q;
  logic             mck_full;

  assign rise     = sync_q[1] & ~sync_q[2];
  assign mck_full = (mck_q == {MCK_W{1'b1}});
  assign stall_o  = !rise && (per_q == PER_W'(PER_SAT));
  assign meas_o   = rise && armed_q;
  assign period_o = per_q;
  // count of this frame includes a pulse coincident with the closing edge
  assign mck_o    = (mclk_en_i && !mck_full) ? mck_q + MCK_W'(1) : mck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      armed_q <= 1'b0;
      per_q   <= '0;
      mck_q   <= '0;
    end else begin
      sync_q <= {sync_q[1:0], frame_clk_i};
      if (rise) begin
        armed_q <= 1'b1;
        per_q   <= PER_W'(1);
        mck_q   <= '0;
      end else begin
        if (stall_o) armed_q <= 1'b0;
        if (per_q != PER_W'(PER_SAT)) per_q <= per_q + PER_W'(1);
        if (mclk_en_i && !mck_full) mck_q <= mck_q + MCK_W'(1);
      end
    end
  end

endmodule

// File: rtl/fs_rate_class.sv
module fs_rate_class
  import fs_mode_pkg::*;
#(
  parameter int PER_W   = 15,
  parameter int QD_MIN  = 500,
  parameter int QD_MAX  = 588,
  parameter int DBL_MIN = 1000,
  parameter int DBL_MAX = 1190,
  parameter int SGL_MIN = 2000,
  parameter int SGL_MAX = 25000
) (
  input  logic [PER_W-1:0] period_i,
  output spd_e             cls_o
);

  int p;

  always_comb begin
    p = int'(period_i);
    if (p >= QD_MIN && p <= QD_MAX)        cls_o = SPD_QD;
    else if (p >= DBL_MIN && p <= DBL_MAX) cls_o = SPD_DBL;
    else if (p >= SGL_MIN && p <= SGL_MAX) cls_o = SPD_SGL;
    else                                   cls_o = SPD_NONE;
  end

endmodule

// File: rtl/fs_mode_filter.sv
module fs_mode_filter
  import fs_mode_pkg::*;
#(
  parameter int ACCEPT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic meas_i,
  input  logic stall_i,
  input  spd_e cls_i,
  output spd_e mode_o
);

  localparam int CW = $clog2(ACCEPT + 1);

  spd_e          cand_q;
  spd_e          mode_q;
  logic [CW-1:0] hcnt_q;
  logic [CW-1:0] hnxt;

  always_comb begin
    if (cls_i != cand_q)                hnxt = CW'(1);
    else if (hcnt_q == CW'(ACCEPT))     hnxt = hcnt_q;
    else                                hnxt = hcnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= SPD_NONE;
      hcnt_q <= '0;
      mode_q <= SPD_NONE;
    end else if (stall_i) begin
      cand_q <= SPD_NONE;
      hcnt_q <= '0;
      mode_q <= SPD_NONE;
    end else if (meas_i) begin
      cand_q <= cls_i;
      hcnt_q <= hnxt;
      if (hnxt == CW'(ACCEPT)) mode_q <= cls_i;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/fs_ratio_check.sv
module fs_ratio_check
  import fs_mode_pkg::*;
#(
  parameter int MCK_W     = 11,
  parameter int RATIO_TOL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_i,
  input  logic             stall_i,
  input  logic [MCK_W-1:0] mck_i,
  input  spd_e             mode_i,
  output logic [2:0]       code_o,
  output logic             valid_o
);

  logic [NUM_RATIOS-1:0] hit;
  logic [2:0]            code_d;
  logic [2:0]            code_q;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_nom
    localparam int NOM = ratio_nominal(i);
    assign hit[i] = (int'(mck_i) >= NOM - RATIO_TOL) && (int'(mck_i) <= NOM + RATIO_TOL);
  end

  always_comb begin
    code_d = RATIO_NONE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) code_d = 3'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= RATIO_NONE;
    else if (stall_i) code_q <= RATIO_NONE;
    else if (meas_i)  code_q <= code_d;
  end

  assign code_o  = code_q;
  assign valid_o = (mode_i != SPD_NONE) && ratio_legal(mode_i, code_q);

endmodule

// File: rtl/fs_mode_detect.sv
module fs_mode_detect
  import fs_mode_pkg::*;
#(
  parameter int REF_HZ     = 100_000_000,
  parameter int SGL_LO_HZ  = 4_000,
  parameter int SGL_HI_HZ  = 50_000,
  parameter int DBL_LO_HZ  = 84_000,
  parameter int DBL_HI_HZ  = 100_000,
  parameter int QD_LO_HZ   = 170_000,
  parameter int QD_HI_HZ   = 200_000,
  parameter int ACCEPT     = 4,
  parameter int RATIO_TOL  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_clk_i,
  input  logic       mclk_en_i,
  input  logic       deemph_req_i,
  output logic [1:0] mode_o,
  output logic       mode_valid_o,
  output logic [2:0] ratio_code_o,
  output logic       ratio_valid_o,
  output logic       deemph_en_o
);

  localparam int QD_MIN  = (REF_HZ + QD_HI_HZ - 1) / QD_HI_HZ;
  localparam int QD_MAX  = REF_HZ / QD_LO_HZ;
  localparam int DBL_MIN = (REF_HZ + DBL_HI_HZ - 1) / DBL_HI_HZ;
  localparam int DBL_MAX = REF_HZ / DBL_LO_HZ;
  localparam int SGL_MIN = (REF_HZ + SGL_HI_HZ - 1) / SGL_HI_HZ;
  localparam int SGL_MAX = REF_HZ / SGL_LO_HZ;
  localparam int PER_SAT = SGL_MAX + 1;
  localparam int PER_W   = $clog2(PER_SAT + 1);
  localparam int MCK_W   = $clog2(768 + RATIO_TOL + 1) + 1;

  logic             meas_w;
  logic             stall_w;
  logic [PER_W-1:0] period_w;
  logic [MCK_W-1:0] mck_w;
  spd_e             cls_w;
  spd_e             mode_w;

  fs_frame_meter #(.PER_SAT(PER_SAT), .PER_W(PER_W), .MCK_W(MCK_W)) u_meter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_clk_i (frame_clk_i),
    .mclk_en_i   (mclk_en_i),
    .meas_o      (meas_w),
    .stall_o     (stall_w),
    .period_o    (period_w),
    .mck_o       (mck_w)
  );

  fs_rate_class #(
    .PER_W(PER_W), .QD_MIN(QD_MIN), .QD_MAX(QD_MAX), .DBL_MIN(DBL_MIN),
    .DBL_MAX(DBL_MAX), .SGL_MIN(SGL_MIN), .SGL_MAX(SGL_MAX)
  ) u_class (
    .period_i (period_w),
    .cls_o    (cls_w)
  );

  fs_mode_filter #(.ACCEPT(ACCEPT)) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .meas_i  (meas_w),
    .stall_i (stall_w),
    .cls_i   (cls_w),
    .mode_o  (mode_w)
  );

  fs_ratio_check #(.MCK_W(MCK_W), .RATIO_TOL(RATIO_TOL)) u_ratio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .meas_i  (meas_w),
    .stall_i (stall_w),
    .mck_i   (mck_w),
    .mode_i  (mode_w),
    .code_o  (ratio_code_o),
    .valid_o (ratio_valid_o)
  );

  assign mode_o       = mode_w;
  assign mode_valid_o = (mode_w != SPD_NONE);
  assign deemph_en_o  = deemph_req_i && (mode_w == SPD_SGL);

endmodule

// File: rtl/fs_mode_detect_chk.sv
module fs_mode_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_o,
  input logic       mode_valid_o,
  input logic [2:0] ratio_code_o,
  input logic       ratio_valid_o,
  input logic       deemph_req_i,
  input logic       deemph_en_o,
  input logic       meas_i,
  input logic       stall_i
);

  AST_MODE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> $past(meas_i || stall_i)); // R4

  AST_STALL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> (!mode_valid_o && ratio_code_o == 3'b111)); // R7

  AST_CODE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_code_o) |-> $past(meas_i || stall_i)); // R5

  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_code_o != 3'd6); // R5

  AST_RATIO_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_valid_o |-> (mode_valid_o && ratio_code_o != 3'b111)); // R6

  AST_DEEMPH_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deemph_en_o |-> (deemph_req_i && mode_o == 2'b00)); // R8

endmodule

bind fs_mode_detect fs_mode_detect_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_o        (mode_o),
  .mode_valid_o  (mode_valid_o),
  .ratio_code_o  (ratio_code_o),
  .ratio_valid_o (ratio_valid_o),
  .deemph_req_i  (deemph_req_i),
  .deemph_en_o   (deemph_en_o),
  .meas_i        (meas_w),
  .stall_i       (stall_w)
);

// File: tb/tb_fs_mode_detect.sv
module tb_fs_mode_detect;

  localparam int REF_HZ    = 40_000_000;
  localparam int SGL_LO_HZ = 16_000;
  localparam int QD_MIN    = (REF_HZ + 200_000 - 1) / 200_000;
  localparam int QD_MAX    = REF_HZ / 170_000;
  localparam int DBL_MIN   = (REF_HZ + 100_000 - 1) / 100_000;
  localparam int DBL_MAX   = REF_HZ / 84_000;
  localparam int SGL_MIN   = (REF_HZ + 50_000 - 1) / 50_000;
  localparam int SGL_MAX   = REF_HZ / SGL_LO_HZ;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_clk = 1'b0;
  logic       mclk_en = 1'b0;
  logic       deemph_req = 1'b0;
  logic [1:0] mode;
  logic       mode_valid;
  logic [2:0] ratio_code;
  logic       ratio_valid;
  logic       deemph_en;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fs_mode_detect #(.REF_HZ(REF_HZ), .SGL_LO_HZ(SGL_LO_HZ)) dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .frame_clk_i   (frame_clk),
    .mclk_en_i     (mclk_en),
    .deemph_req_i  (deemph_req),
    .mode_o        (mode),
    .mode_valid_o  (mode_valid),
    .ratio_code_o  (ratio_code),
    .ratio_valid_o (ratio_valid),
    .deemph_en_o   (deemph_en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_mode(input int p);
    if (p >= QD_MIN && p <= QD_MAX)   return 2;
    if (p >= DBL_MIN && p <= DBL_MAX) return 1;
    if (p >= SGL_MIN && p <= SGL_MAX) return 0;
    return 3;
  endfunction

  // n frames of period p, nk master pulses at the start of each frame
  task automatic run_frames(input int p, input int n, input int nk);
    for (int f = 0; f < n; f++) begin
      for (int i = 0; i < p; i++) begin
        @(negedge clk);
        frame_clk = (i < p / 2);
        mclk_en   = (i < nk);
      end
    end
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) begin
      @(negedge clk);
      frame_clk = 1'b0;
      mclk_en   = 1'b0;
    end
  endtask

  task automatic ratio_case(input int p, input int nk, input int code, input int vld);
    run_frames(p, 5, nk);
    chk("R5", $sformatf("ratio code p=%0d n=%0d", p, nk), int'(ratio_code), code);
    chk("R6", $sformatf("ratio valid p=%0d n=%0d", p, nk), int'(ratio_valid), vld);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int plist[14] = '{199, 200, 235, 236, 300, 399, 400, 476, 477, 600, 799, 800, 2500, 2501};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mode", int'(mode), 3);
    chk("R1", "mode_valid", int'(mode_valid), 0);
    chk("R1", "ratio_code", int'(ratio_code), 7);
    chk("R1", "ratio_valid", int'(ratio_valid), 0);
    deemph_req = 1'b1;
    @(negedge clk);
    chk("R1", "deemph_en", int'(deemph_en), 0);
    deemph_req = 1'b0;
    rst_n = 1'b1;
    idle(4);

    // R2 / R3 band edge sweep
    foreach (plist[k]) begin
      run_frames(plist[k], 5, 0);
      chk("R2", $sformatf("mode p=%0d", plist[k]), int'(mode), exp_mode(plist[k]));
      chk("R3", $sformatf("valid p=%0d", plist[k]), int'(mode_valid),
          (exp_mode(plist[k]) != 3) ? 1 : 0);
    end

    // R5 / R6 ratios per band
    ratio_case(200, 192, 1, 1);
    ratio_case(200, 128, 0, 1);
    ratio_case(200, 130, 0, 1);
    ratio_case(200, 131, 7, 0);
    ratio_case(200, 126, 0, 1);
    ratio_case(400, 384, 3, 1);
    ratio_case(400, 256, 2, 1);
    ratio_case(450, 192, 1, 1);
    ratio_case(1000, 768, 5, 1);
    ratio_case(1000, 766, 5, 1);
    ratio_case(1000, 765, 7, 0);
    ratio_case(1000, 512, 4, 1);
    ratio_case(1000, 128, 0, 0);
    ratio_case(1000, 192, 1, 0);

    // R8 de-emphasis gating (single speed settled)
    deemph_req = 1'b1;
    @(negedge clk);
    chk("R8", "deemph single req=1", int'(deemph_en), 1);
    deemph_req = 1'b0;
    @(negedge clk);
    chk("R8", "deemph single req=0", int'(deemph_en), 0);

    // R4 hysteresis: three frames hold, fourth switches
    run_frames(210, 5, 0);
    chk("R4", "settled quad", int'(mode), 2);
    deemph_req = 1'b1;
    @(negedge clk);
    chk("R8", "deemph quad req=1", int'(deemph_en), 0);
    deemph_req = 1'b0;
    run_frames(420, 4, 0);
    chk("R4", "three double frames keep quad", int'(mode), 2);
    run_frames(420, 1, 0);
    chk("R4", "fourth double frame switches", int'(mode), 1);
    // R4 interrupted run restarts the count
    run_frames(210, 5, 0);
    chk("R4", "back to quad", int'(mode), 2);
    run_frames(420, 3, 0);
    run_frames(210, 1, 0);
    run_frames(420, 3, 0);
    chk("R4", "interrupted run keeps quad", int'(mode), 2);
    run_frames(420, 2, 0);
    chk("R4", "four after break switches", int'(mode), 1);

    // R7 stopped frame clock
    run_frames(1000, 5, 256);
    chk("R7", "single before stop", int'(mode), 0);
    chk("R7", "ratio valid before stop", int'(ratio_valid), 1);
    idle(1400);
    chk("R7", "still valid below limit", int'(mode_valid), 1);
    idle(200);
    chk("R7", "mode after stop", int'(mode), 3);
    chk("R7", "valid after stop", int'(mode_valid), 0);
    chk("R7", "ratio code after stop", int'(ratio_code), 7);
    chk("R7", "ratio valid after stop", int'(ratio_valid), 0);
    run_frames(1000, 5, 256);
    chk("R7", "recovered single", int'(mode), 0);
    chk("R7", "recovered ratio", int'(ratio_code), 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule